// File: doc/BRIEF.md
# Weighted Threshold Element with Hysteresis

This block is a clocked model of a state-holding threshold gate of the kind used in dual-rail, null-separated asynchronous logic. It has up to four single-rail inputs. Each input has a positive integer weight that is fixed at elaboration. One output rail moves to Data when the weights of the asserted inputs add up to at least a threshold. After that, the output stays at Data for as long as any input is still asserted. It returns to Null only once every input has returned to Null. The output changes only on a rising clock edge, so a netlist built from these elements stays fully synchronous and can be synthesized.

A two-state machine holds the output. In state ST_NULL the output is Null. Transition T_FIRE goes to ST_DATA when the weighted sum sampled at an edge reaches the threshold. In state ST_DATA the output is Data. Transition T_RELEASE goes back to ST_NULL when the sampled sum is zero. Every other case takes T_HOLD, which keeps the present state. A synchronous reset puts the machine in ST_NULL. To build a specific gate, the instantiating code sets the input count, the packed weight vector (input 0 in the lowest field) and the threshold.

Top module: `thg_gate`

## Requirements
- R1: Asserting `rst` at a rising edge leaves `rail_out` at 0 (Null) after that edge, whatever the inputs and the previous output.
- R2: From Null, if the weighted sum of asserted inputs at a rising edge is greater than or equal to `THRESH`, `rail_out` is 1 (Data) after that edge.
- R3: From Null, if the weighted sum at an edge is below `THRESH`, `rail_out` stays 0. This includes a sum that is non-zero.
- R4: From Data, if at least one input is asserted at an edge, `rail_out` stays 1, even when the sum is below `THRESH`.
- R5: From Data, if every input is 0 at an edge, `rail_out` becomes 0 after that edge.
- R6: With three inputs of weight 1 and threshold 2, any two asserted inputs set the output.
- R7: With three inputs of weight 1 and threshold 3, the output is set only when all three inputs are asserted.
- R8: With weights A=2, B=1, C=1 (inputs 0, 1, 2) and threshold 2, the output is set by A alone or by B and C together, and not by B or C alone.
- R9: With weights A=3, B=C=D=1 (inputs 0 to 3) and threshold 4, the output is set by A together with any other input, and not by A alone or by B, C and D together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, forces Null |
| rails_in | input | N_IN | Input rails; bit i has weight field i of WEIGHTS |
| rail_out | output | 1 | Output rail, 1 = Data, 0 = Null |

## Verification
The bench focuses on the gap between the set condition and the clear condition. It drives sums that are non-zero but below the threshold, both from Null and from Data. A design that clears when the sum drops below the threshold loses Data in the hold steps. A design that sets on any non-zero sum asserts in the sub-threshold steps. The same input stream is applied to four weight and threshold configurations at once. This catches wrong field order or wrong weight extraction: for example, B, C and D together must stay below the four-input threshold while A with one partner must reach it. Reset is applied while the outputs hold Data and the inputs are still asserted. A reset that only blocks new sets would leave the output at Data.

// File: rtl/thg_pkg.sv
package thg_pkg;

    typedef enum logic {
        ST_NULL = 1'b0,
        ST_DATA = 1'b1
    } thg_state_t;

    typedef enum logic [1:0] {
        LV_NULL    = 2'd0,
        LV_PARTIAL = 2'd1,
        LV_REACHED = 2'd2
    } thg_level_t;

    function automatic int unsigned weight_of(input logic [63:0] packed_w,
                                              input int unsigned idx,
                                              input int unsigned wbits);
        logic [63:0] mask;
        mask = (64'd1 << wbits) - 64'd1;
        return int'((packed_w >> (idx * wbits)) & mask);
    endfunction

    function automatic int unsigned weight_total(input logic [63:0] packed_w,
                                                 input int unsigned n,
                                                 input int unsigned wbits);
        int unsigned acc;
        acc = 0;
        for (int unsigned i = 0; i < n; i++) begin
            acc = acc + weight_of(packed_w, i, wbits);
        end
        return acc;
    endfunction

endpackage

// File: rtl/thg_weight_sum.sv
module thg_weight_sum #(
    parameter int unsigned                  N_IN     = 3,
    parameter int unsigned                  WEIGHT_W = 4,
    parameter logic [N_IN*WEIGHT_W-1:0]     WEIGHTS  = '0,
    parameter int unsigned                  SUM_W    = 2
) (
    input  logic [N_IN-1:0]  rails,
    output logic [SUM_W-1:0] sum
);

    logic [SUM_W-1:0] term [N_IN];

    for (genvar i = 0; i < N_IN; i++) begin : g_term
        localparam logic [WEIGHT_W-1:0] WI = WEIGHTS[i*WEIGHT_W +: WEIGHT_W];
        assign term[i] = rails[i] ? SUM_W'(WI) : '0;
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < N_IN; i++) begin
            sum = sum + term[i];
        end
    end

endmodule

// File: rtl/thg_level.sv
module thg_level
    import thg_pkg::*;
#(
    parameter int unsigned SUM_W  = 2,
    parameter int unsigned THRESH = 2
) (
    input  logic [SUM_W-1:0] sum,
    output thg_level_t       level
);

    logic is_zero;
    logic is_reached;

    assign is_zero    = (sum == '0);
    assign is_reached = (32'(sum) >= 32'(THRESH));

    always_comb begin
        if (is_zero) begin
            level = LV_NULL;
        end else if (is_reached) begin
            level = LV_REACHED;
        end else begin
            level = LV_PARTIAL;
        end
    end

endmodule

// File: rtl/thg_fsm.sv
module thg_fsm
    import thg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  thg_level_t level,
    output logic       rail_out
);

    thg_state_t state_q;
    thg_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_NULL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NULL: begin
                if (level == LV_REACHED) begin
                    state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (level == LV_NULL) begin
                    state_d = ST_NULL;
                end
            end
            default: state_d = ST_NULL;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_DATA: rail_out = 1'b1;
            default: rail_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/thg_gate.sv
module thg_gate
    import thg_pkg::*;
#(
    parameter int unsigned              N_IN     = 3,
    parameter int unsigned              WEIGHT_W = 4,
    parameter logic [N_IN*WEIGHT_W-1:0] WEIGHTS  = {4'd1, 4'd1, 4'd1},
    parameter int unsigned              THRESH   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] rails_in,
    output logic            rail_out
);

    localparam int unsigned TOTAL = weight_total(64'(WEIGHTS), N_IN, WEIGHT_W);
    localparam int unsigned SUM_W = (TOTAL < 2) ? 1 : $clog2(TOTAL + 1);

    logic [SUM_W-1:0] sum;
    thg_level_t       level;

    thg_weight_sum #(
        .N_IN     (N_IN),
        .WEIGHT_W (WEIGHT_W),
        .WEIGHTS  (WEIGHTS),
        .SUM_W    (SUM_W)
    ) u_sum (
        .rails (rails_in),
        .sum   (sum)
    );

    thg_level #(
        .SUM_W  (SUM_W),
        .THRESH (THRESH)
    ) u_level (
        .sum   (sum),
        .level (level)
    );

    thg_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .level    (level),
        .rail_out (rail_out)
    );

endmodule

// File: rtl/thg_gate_chk.sv
module thg_gate_chk #(
    parameter int unsigned              N_IN     = 3,
    parameter int unsigned              WEIGHT_W = 4,
    parameter logic [N_IN*WEIGHT_W-1:0] WEIGHTS  = {4'd1, 4'd1, 4'd1},
    parameter int unsigned              THRESH   = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [N_IN-1:0] rails_in,
    input logic            rail_out
);

    int unsigned chk_sum;
    logic        at_thresh;
    logic        all_null;

    always_comb begin
        chk_sum = 0;
        for (int i = 0; i < N_IN; i++) begin
            if (rails_in[i]) begin
                chk_sum = chk_sum + int'(WEIGHTS[i*WEIGHT_W +: WEIGHT_W]);
            end
        end
    end

    assign at_thresh = (chk_sum >= THRESH);
    assign all_null  = (rails_in == '0);

    // R1: reset returns the output to Null
    a_r1_reset_null: assert property (@(posedge clk)
        rst |=> !rail_out);

    // R2: threshold reached from Null sets Data
    a_r2_fire: assert property (@(posedge clk) disable iff (rst)
        (!rail_out && at_thresh) |=> rail_out);

    // R3: below threshold from Null keeps Null
    a_r3_no_early_fire: assert property (@(posedge clk) disable iff (rst)
        (!rail_out && !at_thresh) |=> !rail_out);

    // R4: any asserted input holds Data
    a_r4_hold_data: assert property (@(posedge clk) disable iff (rst)
        (rail_out && !all_null) |=> rail_out);

    // R5: all-Null inputs release Data
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        (rail_out && all_null) |=> !rail_out);

endmodule

bind thg_gate thg_gate_chk #(
    .N_IN     (N_IN),
    .WEIGHT_W (WEIGHT_W),
    .WEIGHTS  (WEIGHTS),
    .THRESH   (THRESH)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rails_in (rails_in),
    .rail_out (rail_out)
);

// File: tb/thg_gate_test.sv
module thg_gate_test;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] stim = 4'b0000;
    logic [3:0] outs;
    logic       done = 1'b0;
    int         checks = 0;
    int         failures = 0;
    exp_item_t  sb [$];

    always #5 clk = ~clk;

    // gate 0: 2-of-3, weights 1,1,1
    thg_gate #(.N_IN(3), .WEIGHT_W(4), .WEIGHTS(12'h111), .THRESH(2)) uut (
        .clk(clk), .rst(rst), .rails_in(stim[2:0]), .rail_out(outs[0]));
    // gate 1: 3-of-3
    thg_gate #(.N_IN(3), .WEIGHT_W(4), .WEIGHTS(12'h111), .THRESH(3)) uut_all3 (
        .clk(clk), .rst(rst), .rails_in(stim[2:0]), .rail_out(outs[1]));
    // gate 2: A=2, B=1, C=1, threshold 2
    thg_gate #(.N_IN(3), .WEIGHT_W(4), .WEIGHTS(12'h112), .THRESH(2)) uut_abc (
        .clk(clk), .rst(rst), .rails_in(stim[2:0]), .rail_out(outs[2]));
    // gate 3: A=3, B=C=D=1, threshold 4
    thg_gate #(.N_IN(4), .WEIGHT_W(4), .WEIGHTS(16'h1113), .THRESH(4)) uut_quad (
        .clk(clk), .rst(rst), .rails_in(stim), .rail_out(outs[3]));

    task automatic drive(input logic r, input logic [3:0] v,
                         input logic [3:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        rst  = r;
        stim = v;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_item_t it;
            it = sb.pop_front();
            for (int g = 0; g < 4; g++) begin
                checks++;
                if (outs[g] !== it.exp[g]) begin
                    failures++;
                    $display("FAIL %s gate%0d actual=%b expected=%b",
                             it.tag, g, outs[g], it.exp[g]);
                end
            end
        end
    end

    initial begin
        // expected vector is {gate3, gate2, gate1, gate0}
        drive(1'b1, 4'b1111, 4'b0000, "R1 reset with inputs high");
        drive(1'b0, 4'b0000, 4'b0000, "R1 idle after reset");
        drive(1'b0, 4'b0001, 4'b0100, "R3 R8 A alone");
        drive(1'b0, 4'b0011, 4'b1101, "R2 R6 R7 R9 A+B");
        drive(1'b0, 4'b0010, 4'b1101, "R4 hold on B");
        drive(1'b0, 4'b0000, 4'b0000, "R5 release");
        drive(1'b0, 4'b1110, 4'b0101, "R6 R8 R9 B+C+D");
        drive(1'b0, 4'b0000, 4'b0000, "R5 release");
        drive(1'b0, 4'b0100, 4'b0000, "R3 R8 C alone");
        drive(1'b0, 4'b0111, 4'b1111, "R2 R7 A+B+C");
        drive(1'b0, 4'b0001, 4'b1111, "R4 hold on A");
        drive(1'b0, 4'b1000, 4'b1000, "R4 R5 D only");
        drive(1'b0, 4'b0000, 4'b0000, "R5 release");
        drive(1'b0, 4'b0110, 4'b0101, "R6 B+C");
        drive(1'b1, 4'b0110, 4'b0000, "R1 reset from Data");
        drive(1'b0, 4'b0110, 4'b0101, "R2 refire after reset");
        drive(1'b0, 4'b0101, 4'b1101, "R9 R6 A+C");
        drive(1'b0, 4'b0000, 4'b0000, "R5 release");
        drive(1'b0, 4'b0001, 4'b0100, "R3 rearm needs threshold");
        drive(1'b0, 4'b0000, 4'b0000, "R5 release");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule